// File: doc/BRIEF.md
# TDM Frame State Counter

This block keeps the position within a 125 µs TDM frame for a time-slot interchanger. A 13-bit register advances once per cycle of a 65.536 MHz clock and wraps after 8192 cycles, which is exactly one frame. The count splits into three fields. The top seven bits give the time slot. The next four bits give the access state, also called the stream index. The low two bits give the sub-phase within an access state. Each access state therefore lasts four clocks (about 61 ns). Sixteen access states make up one 976 ns slot period.

From the access state the block decodes a set of memory access windows. Exactly one window is open in every clock: connection memory read, bus data read, bus data write, data SRAM, or microprocessor. Memory sequencers elsewhere in the chip qualify their accesses with these windows.

A frame sync pulse realigns the count to zero. If the sync arrives when the counter was not about to wrap by itself, a sticky slip flag is raised. For diagnostics the count can be reset, or loaded with any value.

Top module: `tdm_state_counter`

## Requirements
- R1: While rstN is low, and after its release until the first clock edge, count is 0, slip is 0 and termCnt is 0.
- R2: With loadEn and syncIn both low, count increases by one on each rising clock edge and goes from 8191 to 0.
- R3: slot equals count[12:6], stream equals count[5:2] and phase equals count[1:0].
- R4: termCnt is 1 exactly when count is 8191. The following edge without load or sync brings count to 0.
- R5: syncIn high with loadEn low at a rising edge makes count 0 after that edge.
- R6: A sync that is acted on (loadEn low) while count is not 8191 sets slip to 1. slip then stays 1 until rstN is asserted. A sync that is acted on while count is 8191 leaves slip unchanged.
- R7: loadEn high at a rising edge makes count equal loadVal after that edge. This holds whether syncIn is high or low. A sync coinciding with a load neither clears the count nor sets slip.
- R8: The windows are decoded from stream[2:0] as follows. Value 0 opens cmRdWin, 1 opens busRdWin, 2 opens sramWin, 3 opens busWrWin, and 4 to 7 open cpuWin. Exactly one window output is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 65.536 MHz state clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncIn | input | 1 | Frame sync pulse, realigns count to 0 |
| loadEn | input | 1 | Diagnostic load strobe |
| loadVal | input | 13 | Value written on a diagnostic load |
| count | output | 13 | Current frame position |
| slot | output | 7 | Time-slot field |
| stream | output | 4 | Stream / access-state field |
| phase | output | 2 | Sub-phase within an access state |
| termCnt | output | 1 | High while count is 8191 |
| slip | output | 1 | Sticky flag: a sync arrived out of alignment |
| cmRdWin | output | 1 | Connection memory read window |
| busRdWin | output | 1 | Bus data read window |
| busWrWin | output | 1 | Bus data write window |
| sramWin | output | 1 | Data SRAM access window |
| cpuWin | output | 1 | Microprocessor access window |

## Verification
Several rules are checked on every clock: increment by one, clearing on an accepted sync, taking the loaded value, wrapping after terminal count, setting slip on a misaligned sync, slip staying set, and exactly one window being open. These checks relate inputs to the count one edge later. Some behaviours only the directed scenarios can show. One is the exact field positions. Another is the mapping of each access state to its particular window. A third is that a sync arriving at 8191 or together with a load leaves slip clear. The last is that reset clears a slip that was set earlier.

// File: rtl/tdm_sc_pkg.sv
package tdm_sc_pkg;

  // Per-cycle action chosen by the control; at most one bit is set.
  typedef struct packed {
    logic doLoad;
    logic doClear;
    logic doInc;
  } sc_ctrl_t;

endpackage

// File: rtl/tdm_sc_ctrl.sv
module tdm_sc_ctrl
  import tdm_sc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     syncIn,
  input  logic     loadEn,
  input  logic     atTerm,
  output sc_ctrl_t ctrl,
  output logic     slip
);

  // Priority: diagnostic load, then frame sync, then counting.
  always_comb begin
    ctrl.doLoad  = loadEn;
    ctrl.doClear = syncIn & ~loadEn;
    ctrl.doInc   = ~loadEn & ~syncIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slip <= 1'b0;
    end else if (ctrl.doClear && !atTerm) begin
      slip <= 1'b1;
    end
  end

  AST_SLIP_ON_MISALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && !loadEn && !atTerm) |=> slip); // R6

  AST_SLIP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    slip |=> slip); // R6

endmodule

// File: rtl/tdm_sc_datapath.sv
module tdm_sc_datapath
  import tdm_sc_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  sc_ctrl_t         ctrl,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cnt,
  output logic             atTerm
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctrl.doLoad) begin
      cnt <= loadVal;
    end else if (ctrl.doClear) begin
      cnt <= '0;
    end else if (ctrl.doInc) begin
      cnt <= cnt + ONE;
    end
  end

  assign atTerm = &cnt;

  AST_WRAP_AFTER_TERM: assert property (@(posedge clk) disable iff (!rstN)
    (atTerm && ctrl.doInc) |=> (cnt == '0)); // R4

endmodule

// File: rtl/tdm_sc_window.sv
module tdm_sc_window #(
  parameter int IDX_W   = 3,
  parameter int CPU_MIN = 4
) (
  input  logic [IDX_W-1:0] accIdx,
  output logic             cmRdWin,
  output logic             busRdWin,
  output logic             busWrWin,
  output logic             sramWin,
  output logic             cpuWin
);

  localparam int N_FIXED = 4;
  logic [N_FIXED-1:0] fixedHit;

  // One comparator per dedicated access state.
  for (genvar g = 0; g < N_FIXED; g++) begin : g_fixed
    assign fixedHit[g] = (accIdx == IDX_W'(g));
  end

  assign cmRdWin  = fixedHit[0];
  assign busRdWin = fixedHit[1];
  assign sramWin  = fixedHit[2];
  assign busWrWin = fixedHit[3];
  assign cpuWin   = (int'(accIdx) >= CPU_MIN);

endmodule

// File: rtl/tdm_state_counter.sv
module tdm_state_counter
  import tdm_sc_pkg::*;
#(
  parameter int SLOT_W   = 7,
  parameter int STREAM_W = 4,
  parameter int PHASE_W  = 2,
  localparam int CNT_W   = SLOT_W + STREAM_W + PHASE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                syncIn,
  input  logic                loadEn,
  input  logic [CNT_W-1:0]    loadVal,
  output logic [CNT_W-1:0]    count,
  output logic [SLOT_W-1:0]   slot,
  output logic [STREAM_W-1:0] stream,
  output logic [PHASE_W-1:0]  phase,
  output logic                termCnt,
  output logic                slip,
  output logic                cmRdWin,
  output logic                busRdWin,
  output logic                busWrWin,
  output logic                sramWin,
  output logic                cpuWin
);

  localparam int WIN_IDX_W = 3;

  sc_ctrl_t ctrl;
  logic     atTerm;

  tdm_sc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .syncIn (syncIn),
    .loadEn (loadEn),
    .atTerm (atTerm),
    .ctrl   (ctrl),
    .slip   (slip)
  );

  tdm_sc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .loadVal (loadVal),
    .cnt     (count),
    .atTerm  (atTerm)
  );

  assign phase   = count[PHASE_W-1:0];
  assign stream  = count[PHASE_W +: STREAM_W];
  assign slot    = count[CNT_W-1 -: SLOT_W];
  assign termCnt = atTerm;

  tdm_sc_window #(.IDX_W(WIN_IDX_W), .CPU_MIN(4)) u_win (
    .accIdx   (stream[WIN_IDX_W-1:0]),
    .cmRdWin  (cmRdWin),
    .busRdWin (busRdWin),
    .busWrWin (busWrWin),
    .sramWin  (sramWin),
    .cpuWin   (cpuWin)
  );

  AST_INCREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !syncIn) |=> (count == $past(count) + CNT_W'(1))); // R2

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && !loadEn) |=> (count == '0)); // R5

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (count == $past(loadVal))); // R7

  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({cmRdWin, busRdWin, busWrWin, sramWin, cpuWin})); // R8

endmodule

// File: tb/tdm_state_counter_tb.sv
module tdm_state_counter_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        syncIn = 1'b0;
  logic        loadEn = 1'b0;
  logic [12:0] loadVal = '0;
  logic [12:0] count;
  logic [6:0]  slot;
  logic [3:0]  stream;
  logic [1:0]  phase;
  logic        termCnt, slip;
  logic        cmRdWin, busRdWin, busWrWin, sramWin, cpuWin;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_state_counter u_dut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .loadEn(loadEn), .loadVal(loadVal),
    .count(count), .slot(slot), .stream(stream), .phase(phase),
    .termCnt(termCnt), .slip(slip),
    .cmRdWin(cmRdWin), .busRdWin(busRdWin), .busWrWin(busWrWin),
    .sramWin(sramWin), .cpuWin(cpuWin)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Window vector {cm, busRd, busWr, sram, cpu} per requirement R8.
  function automatic int expWin(input int c);
    int idx;
    idx = (c >> 2) & 7;
    case (idx)
      0: return 5'b10000;
      1: return 5'b01000;
      2: return 5'b00010;
      3: return 5'b00100;
      default: return 5'b00001;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkFields(input int c);
    chk("R3 slot", int'(slot), (c >> 6) & 127);
    chk("R3 stream", int'(stream), (c >> 2) & 15);
    chk("R3 phase", int'(phase), c & 3);
    chk("R8 windows", int'({cmRdWin, busRdWin, busWrWin, sramWin, cpuWin}), expWin(c));
  endtask

  task automatic doLoad(input int v);
    loadEn = 1'b1; loadVal = 13'(v);
    step();
    loadEn = 1'b0;
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    #(CLK_PERIOD*2);
    chk("R1 count in reset", int'(count), 0);
    chk("R1 slip in reset", int'(slip), 0);
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 count after release", int'(count), 0);
    chk("R1 termCnt after release", int'(termCnt), 0);
  endtask

  task automatic tCount();
    for (int i = 1; i <= 150; i++) begin
      step();
      chk("R2 increment", int'(count), i);
      checkFields(i);
    end
  endtask

  task automatic tWrap();
    doLoad(8189);
    chk("R7 load value", int'(count), 8189);
    chk("R4 termCnt low at 8189", int'(termCnt), 0);
    step();
    chk("R2 count 8190", int'(count), 8190);
    step();
    chk("R2 count 8191", int'(count), 8191);
    chk("R4 termCnt high at 8191", int'(termCnt), 1);
    checkFields(8191);
    step();
    chk("R2 wrap to 0", int'(count), 0);
    chk("R4 termCnt low after wrap", int'(termCnt), 0);
  endtask

  task automatic tSyncAligned();
    doLoad(8191);
    syncIn = 1'b1;
    step();
    syncIn = 1'b0;
    chk("R5 sync at 8191 gives 0", int'(count), 0);
    chk("R6 aligned sync no slip", int'(slip), 0);
  endtask

  task automatic tSyncSlip();
    doLoad(100);
    step();
    chk("R2 count 101", int'(count), 101);
    syncIn = 1'b1;
    step();
    syncIn = 1'b0;
    chk("R5 sync clears count", int'(count), 0);
    chk("R6 slip set", int'(slip), 1);
    for (int i = 0; i < 5; i++) step();
    chk("R6 slip sticky", int'(slip), 1);
    chk("R2 count after sync", int'(count), 5);
  endtask

  task automatic tLoadWins();
    applyReset();
    chk("R6 reset clears slip", int'(slip), 0);
    step();
    loadEn = 1'b1; syncIn = 1'b1; loadVal = 13'd500;
    step();
    loadEn = 1'b0; syncIn = 1'b0;
    chk("R7 load beats sync", int'(count), 500);
    chk("R7 no slip with load", int'(slip), 0);
  endtask

  task automatic tWindows();
    for (int s = 0; s < 16; s++) begin
      doLoad((s << 2) | 3 | (s << 6));
      checkFields((s << 2) | 3 | (s << 6));
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    @(negedge clk);
    applyReset();
    tCount();
    tWrap();
    tSyncAligned();
    tSyncSlip();
    tLoadWins();
    tWindows();
    finish();
  end

endmodule